// File: doc/BRIEF.md
# Legacy Region Access Steering Unit

This block decides, for each memory request that lands in the upper legacy shadow window (0D8000h up to 0EFFFFh), whether the access is served by DRAM or forwarded to a downstream legacy port. The window is split into six 16 KB segments. Each segment owns a 2-bit attribute inside one software-writable 32-bit register. The attribute steers reads and writes separately, so a segment can be shadowed read-only, write-only, fully, or not at all.

Requests arrive over a valid/ready handshake carrying a 20-bit address and a read/write flag. One cycle after a request is accepted, a registered response presents the steering decision. A separate flag marks addresses that fall outside the six segments. Such requests are always steered to the legacy port. The response holds while the consumer stalls it.

Top module: `shadow_steer`

## Requirements
- R1: After reset the attribute register reads 0, no response is valid, and every in-window request is steered to the legacy port.
- R2: The attribute register is written and read only as a whole 32-bit word. A write in one cycle is visible on the readback port from the next cycle on.
- R3: Register bits outside the six attribute fields always read 0, and writing them has no effect. The attribute bit mask is 0x00333333.
- R4: The segment starting at 0D8000h + k*4000h, for k = 0 to 5, uses register bits 4k+1:4k. The segment is picked from address bits 19:14.
- R5: Attribute 00 steers both reads and writes of its segment to the legacy port (rsp_to_dram = 0).
- R6: Attribute 01 steers reads to DRAM and writes to the legacy port.
- R7: Attribute 10 steers writes to DRAM and reads to the legacy port.
- R8: Attribute 11 steers both reads and writes to DRAM.
- R9: A request below 0D8000h or above 0EFFFFh gives rsp_out_of_window = 1 and rsp_to_dram = 0. A request inside the window gives rsp_out_of_window = 0.
- R10: A request accepted in cycle t gives rsp_valid in cycle t+1. The request uses the register value from before any write in cycle t, so a write only affects requests accepted in later cycles.
- R11: req_ready is 1 when no response is pending or rsp_ready is 1. While rsp_valid = 1 and rsp_ready = 0, the response and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Whole-word write strobe for the attribute register |
| cfg_wr_data | input | 32 | Write data for the attribute register |
| cfg_rd_data | output | 32 | Current attribute register contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 20 | Request address |
| req_is_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Steering decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = legacy port |
| rsp_out_of_window | output | 1 | Address lies outside the six segments |

## Verification
The assertions check every cycle that unused register bits stay zero, that a write appears masked on the readback port, that an accepted request produces a response next cycle, that a stalled response stays stable, and that out-of-window results never go to DRAM. The mapping of each segment to its register field and the four attribute encodings for reads and writes can only be shown by the bench. The bench sweeps segment edges under mixed attributes, runs a write that coincides with a request, and compares every cycle against a behavioural model.

// File: rtl/shs_pkg.sv
package shs_pkg;

  // Per-segment steering attribute: bit 0 enables DRAM reads, bit 1 DRAM writes.
  typedef enum logic [1:0] {
    ATTR_LEGACY   = 2'b00,
    ATTR_RD_DRAM  = 2'b01,
    ATTR_WR_DRAM  = 2'b10,
    ATTR_ALL_DRAM = 2'b11
  } attr_e;

  typedef struct packed {
    logic to_dram;
    logic out_of_win;
  } steer_t;

endpackage

// File: rtl/shs_attr_reg.sv
module shs_attr_reg #(
  parameter int REG_W   = 32,
  parameter int NUM_SEG = 6,
  parameter int STRIDE  = 4,
  parameter int ATTR_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [REG_W-1:0]               wr_data,
  output logic [REG_W-1:0]               rd_data,
  output logic [NUM_SEG-1:0][ATTR_W-1:0] seg_attr
);

  logic [REG_W-1:0] field_mask;
  logic [REG_W-1:0] reg_d;
  logic [REG_W-1:0] reg_q;

  // Bits that belong to an attribute field.
  always_comb begin
    field_mask = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      field_mask[i*STRIDE +: ATTR_W] = '1;
    end
  end

  always_comb begin
    reg_d = reg_q;
    if (wr_en) begin
      reg_d = wr_data & field_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q <= reg_d;
    end
  end

  assign rd_data = reg_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_field
    assign seg_attr[g] = reg_q[g*STRIDE +: ATTR_W];
  end

endmodule

// File: rtl/shs_win_decode.sv
module shs_win_decode #(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 14,
  parameter int FIRST_SEG = 54,
  parameter int NUM_SEG   = 6,
  localparam int PAGE_W   = ADDR_W - SEG_SHIFT,
  localparam int IDX_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  seg_idx
);

  localparam logic [PAGE_W:0] PAGE_LO = (PAGE_W+1)'(FIRST_SEG);
  localparam logic [PAGE_W:0] PAGE_HI = (PAGE_W+1)'(FIRST_SEG + NUM_SEG);

  logic [PAGE_W:0] page;
  logic [PAGE_W:0] page_off;

  always_comb begin
    page     = {1'b0, addr[ADDR_W-1:SEG_SHIFT]};
    page_off = page - PAGE_LO;
    in_win   = (page >= PAGE_LO) && (page < PAGE_HI);
    seg_idx  = page_off[IDX_W-1:0];
  end

endmodule

// File: rtl/shs_route_sel.sv
module shs_route_sel
  import shs_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int ATTR_W  = 2,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic [NUM_SEG-1:0][ATTR_W-1:0] seg_attr,
  input  logic [IDX_W-1:0]               seg_idx,
  input  logic                           in_win,
  input  logic                           is_write,
  output steer_t                         steer
);

  logic [ATTR_W-1:0] picked;
  attr_e             attr;
  logic              dram_ok;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (seg_idx == IDX_W'(i)) begin
        picked = seg_attr[i];
      end
    end
    attr = attr_e'(picked[1:0]);
  end

  always_comb begin
    unique case (attr)
      ATTR_LEGACY:   dram_ok = 1'b0;
      ATTR_RD_DRAM:  dram_ok = !is_write;
      ATTR_WR_DRAM:  dram_ok = is_write;
      ATTR_ALL_DRAM: dram_ok = 1'b1;
      default:       dram_ok = 1'b0;
    endcase
  end

  always_comb begin
    steer.out_of_win = !in_win;
    steer.to_dram    = in_win && dram_ok;
  end

endmodule

// File: rtl/shadow_steer.sv
module shadow_steer
  import shs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int REG_W     = 32,
  parameter int NUM_SEG   = 6,
  parameter int SEG_SHIFT = 14,
  parameter int FIRST_SEG = 54,
  parameter int STRIDE    = 4,
  parameter int ATTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_to_dram,
  output logic              rsp_out_of_window
);

  localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  logic [NUM_SEG-1:0][ATTR_W-1:0] seg_attr;
  logic                           in_win;
  logic [IDX_W-1:0]               seg_idx;
  steer_t                         steer_now;

  logic   accept;
  logic   valid_d, valid_q;
  logic   load_en;
  steer_t rsp_d, rsp_q;

  shs_attr_reg #(
    .REG_W  (REG_W),
    .NUM_SEG(NUM_SEG),
    .STRIDE (STRIDE),
    .ATTR_W (ATTR_W)
  ) u_attr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .seg_attr(seg_attr)
  );

  shs_win_decode #(
    .ADDR_W   (ADDR_W),
    .SEG_SHIFT(SEG_SHIFT),
    .FIRST_SEG(FIRST_SEG),
    .NUM_SEG  (NUM_SEG)
  ) u_dec (
    .addr   (req_addr),
    .in_win (in_win),
    .seg_idx(seg_idx)
  );

  shs_route_sel #(
    .NUM_SEG(NUM_SEG),
    .ATTR_W (ATTR_W)
  ) u_sel (
    .seg_attr(seg_attr),
    .seg_idx (seg_idx),
    .in_win  (in_win),
    .is_write(req_is_write),
    .steer   (steer_now)
  );

  // Single response slot: free when empty or being drained this cycle.
  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    valid_d = valid_q;
    rsp_d   = rsp_q;
    load_en = accept;
    if (accept) begin
      valid_d = 1'b1;
      rsp_d   = steer_now;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '{to_dram: 1'b0, out_of_win: 1'b0};
    end else if (load_en) begin
      rsp_q <= rsp_d;
    end
  end

  assign rsp_valid         = valid_q;
  assign rsp_to_dram       = rsp_q.to_dram;
  assign rsp_out_of_window = rsp_q.out_of_win;

endmodule

// File: rtl/shs_checker.sv
module shs_checker #(
  parameter int ADDR_W  = 20,
  parameter int REG_W   = 32,
  parameter int NUM_SEG = 6,
  parameter int STRIDE  = 4,
  parameter int ATTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [REG_W-1:0]  cfg_wr_data,
  input logic [REG_W-1:0]  cfg_rd_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_to_dram,
  input logic              rsp_out_of_window
);

  logic [REG_W-1:0] legal_bits;

  always_comb begin
    legal_bits = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      legal_bits[i*STRIDE +: ATTR_W] = '1;
    end
  end

  // R3: bits outside the attribute fields never read as 1
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~legal_bits) == '0);

  // R2: a whole-word write shows up masked on the next cycle
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == ($past(cfg_wr_data) & legal_bits));

  // R10: an accepted request yields a response one cycle later
  a_r10_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R11: an empty slot always accepts
  a_r11_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R11: a stalled response holds its value
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_to_dram) && $stable(rsp_out_of_window)));

  // R9: an out-of-window response never selects DRAM
  a_r9_oow_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_out_of_window) |-> !rsp_to_dram);

endmodule

bind shadow_steer shs_checker #(
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W),
  .NUM_SEG(NUM_SEG),
  .STRIDE (STRIDE),
  .ATTR_W (ATTR_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_wr_en        (cfg_wr_en),
  .cfg_wr_data      (cfg_wr_data),
  .cfg_rd_data      (cfg_rd_data),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_to_dram      (rsp_to_dram),
  .rsp_out_of_window(rsp_out_of_window)
);

// File: tb/sim_shadow_steer.sv
module sim_shadow_steer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_addr;
  logic        req_is_write;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_to_dram;
  logic        rsp_out_of_window;

  always #2 clk = ~clk;

  shadow_steer u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_write(req_is_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_to_dram(rsp_to_dram), .rsp_out_of_window(rsp_out_of_window)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference
  int unsigned m_reg;
  bit          m_valid;
  bit          m_dram;
  bit          m_oow;
  string       m_tag;

  function automatic void ref_route(input int unsigned addr, input bit wr,
                                    input int unsigned r, output bit dram,
                                    output bit oow, output string tag);
    int unsigned seg, a;
    if (addr < 32'h0D8000 || addr > 32'h0EFFFF) begin
      oow = 1; dram = 0; tag = "R9";
    end else begin
      seg  = (addr - 32'h0D8000) / 32'h4000;
      a    = (r >> (seg * 4)) & 3;
      oow  = 0;
      dram = wr ? a[1] : a[0];
      case (a)
        0: tag = "R5";
        1: tag = "R6";
        2: tag = "R7";
        default: tag = "R8";
      endcase
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg   = 0;
      m_valid = 0;
      m_dram  = 0;
      m_oow   = 0;
      m_tag   = "R1";
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        ref_route(req_addr, req_is_write, m_reg, m_dram, m_oow, m_tag);
        m_valid = 1;
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (cfg_wr_en) m_reg = cfg_wr_data & 32'h00333333;
    end
  end

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("R11", 32'(req_ready), 32'(!m_valid || rsp_ready), "req_ready");
    check("R10", 32'(rsp_valid), 32'(m_valid), "rsp_valid");
    check("R2", cfg_rd_data, m_reg, "cfg_rd_data");
    if (m_valid) begin
      check(m_tag, 32'(rsp_to_dram), 32'(m_dram), "rsp_to_dram");
      check("R9", 32'(rsp_out_of_window), 32'(m_oow), "rsp_out_of_window");
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic issue(input logic [19:0] a, input bit wr);
    req_valid    = 1;
    req_addr     = a;
    req_is_write = wr;
    tick();
    req_valid    = 0;
  endtask

  task automatic write_reg(input logic [31:0] d);
    cfg_wr_en   = 1;
    cfg_wr_data = d;
    tick();
    cfg_wr_en   = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; cfg_wr_en = 0; cfg_wr_data = 0;
    req_valid = 0; req_addr = 0; req_is_write = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    check("R1", cfg_rd_data, 32'h0, "reset register");
    check("R1", 32'(rsp_valid), 32'h0, "reset rsp_valid");
    rst_n = 1;
    tick();

    // R1: all segments legacy after reset
    for (int k = 0; k < 6; k++) begin
      for (int w = 0; w < 2; w++) begin
        issue(20'h0D8000 + 20'(k * 'h4000), w[0]);
        check("R1", 32'(rsp_to_dram), 32'h0, "post-reset steering");
      end
    end

    // R2 / R3: full-word write, unused bits drop
    write_reg(32'hFFFF_FFFF);
    check("R3", cfg_rd_data, 32'h0033_3333, "unused bits masked");
    write_reg(32'hCCCC_CCCC);
    check("R3", cfg_rd_data, 32'h0, "writes to unused bits ignored");

    // R4: segment k gets attribute k%4 -> 0x00103210
    write_reg(32'h0010_3210);
    check("R2", cfg_rd_data, 32'h0010_3210, "pattern readback");
    for (int k = 0; k < 6; k++) begin
      for (int w = 0; w < 2; w++) begin
        for (int e = 0; e < 2; e++) begin
          int unsigned a;
          bit exp;
          a = (k % 4);
          exp = w ? a[1] : a[0];
          issue(20'h0D8000 + 20'(k * 'h4000) + (e ? 20'h3FFF : 20'h0), w[0]);
          check("R4", 32'(rsp_to_dram), 32'(exp), "segment field mapping");
          check("R4", 32'(rsp_out_of_window), 32'h0, "in-window flag");
        end
      end
    end

    // R9: window edges
    issue(20'h0D7FFF, 0);
    check("R9", 32'(rsp_out_of_window), 32'h1, "below window");
    issue(20'h0F0000, 1);
    check("R9", 32'(rsp_out_of_window), 32'h1, "above window");
    check("R9", 32'(rsp_to_dram), 32'h0, "above window legacy");
    issue(20'h00000, 0);
    issue(20'hFFFFF, 1);

    // R11: stall holds response (segment 3 has attribute 11)
    tick();
    rsp_ready = 0;
    issue(20'h0E4000, 0);
    check("R11", 32'(rsp_to_dram), 32'h1, "stalled response value");
    req_valid = 1; req_addr = 20'h00010; req_is_write = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R11", 32'(rsp_to_dram), 32'h1, "held to_dram");
      check("R11", 32'(rsp_out_of_window), 32'h0, "held oow");
      check("R11", 32'(req_ready), 32'h0, "no accept while stalled");
    end
    rsp_ready = 1;
    tick();
    check("R11", 32'(rsp_out_of_window), 32'h1, "drained then accepted");
    req_valid = 0;
    tick();

    // R10: write coinciding with a request uses the old value (segment 0 = 00)
    cfg_wr_en = 1; cfg_wr_data = 32'h0033_3333;
    issue(20'h0D9000, 0);
    cfg_wr_en = 0;
    check("R10", 32'(rsp_to_dram), 32'h0, "same-cycle write not seen");
    issue(20'h0D9000, 0);
    check("R10", 32'(rsp_to_dram), 32'h1, "next request sees write");

    // Mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid    = lfsr[0] | lfsr[1];
      req_is_write = lfsr[2];
      rsp_ready    = lfsr[3] | lfsr[4];
      req_addr     = 20'h0D4000 + 20'({lfsr, lfsr[7:0]} % 32'h20000);
      cfg_wr_en    = (lfsr[11:8] == 4'h5);
      cfg_wr_data  = {lfsr, lfsr ^ 16'h5A3C};
      tick();
    end
    req_valid = 0; cfg_wr_en = 0; rsp_ready = 1;
    tick();

    done = 1;
    summary();
    $finish;
  end

endmodule